// File: doc/BRIEF.md
# Clock Source Control Register with Hardware Write Protection

This block is the control register of a reset-and-clock unit. It holds the enable and ready bits of four clock sources: a multi-speed internal oscillator, a 16 MHz internal oscillator, an external oscillator and the main PLL. A bus write is never copied straight into the register. The block first applies a set of hardware rules that depend on two inputs: which source the system clock switch currently reports, and which source feeds the PLL. A source that is feeding the system clock, directly or through the PLL, cannot be switched off by software.

Ready bits follow their enables in the same update, with no start-up delay. A ready flag is raised for each source that becomes ready while its interrupt enable is set. The flags are cleared through a separate write-1-to-clear input. The block also reports the frequency of the multi-speed oscillator. It takes the range index either from a field of this register or from an externally supplied standby range, and it rejects an index that is out of range.

All state changes on the clock edge that ends a write cycle. Outputs are registered, so they show the new value from that edge onward.

Top module: `clk_ctrl_reg`

## Requirements
- R1: After reset `ctrlReg` reads 0x00000063. That value has multi-speed enable (bit 0) = 1, multi-speed ready (bit 1) = 1 and the range field (bits 7:4) = 6. All other bits are 0, `msiFreqHz` = 4000000, `rdyFlags` = 0 and `irqOut` = 0. The flag order is bit 0 multi-speed, bit 1 16 MHz internal, bit 2 external, bit 3 PLL.
- R2: On a write, the ready bits ignore the written data. Those bits are bit 1, bit 9 (16 MHz ready), bit 17 (external ready) and bit 25 (PLL ready). The range-select bit (bit 2) is read-set: once it is 1, writing 0 leaves it at 1 until reset. Unlisted bits always read 0.
- R3: A write while `sysSw` = 2'b11 (PLL) leaves the PLL enable (bit 24) at 1. In that write the PLL ready bit keeps its previous value and the PLL flag is not set.
- R4: A write while `sysSw` = 2'b10 (external), or while `pllSrc` = 2'b11 (external), leaves the external enable (bit 16) at 1. In that write the external ready bit keeps its previous value and no external flag is set.
- R5: A write while `sysSw` = 2'b01, or while `pllSrc` = 2'b10 (16 MHz internal), forces the 16 MHz enable (bit 8) and ready (bit 9) to 1. The 16 MHz flag is set if its interrupt enable is 1.
- R6: A write while `sysSw` = 2'b00, or while `pllSrc` = 2'b01 (multi-speed), forces the multi-speed enable and ready to 1. The multi-speed flag is set only if the enable was 0 before the write and its interrupt enable is 1.
- R7: For a source with no protection or forcing in a write, enable and ready both take the written enable bit. The source's flag is set when that bit is 1 and the source's `srcIrqEn` bit is 1.
- R8: When the multi-speed oscillator ends a write enabled, the range index is chosen by the range-select bit. If the bit is 1 the index is the written range field; if it is 0 the index is `stbyRange`. Indices 0 to 11 give, in Hz: 100k, 200k, 400k, 800k, 1M, 2M, 4M, 8M, 16M, 24M, 32M and 48M, which `msiFreqHz` then reports.
- R9: If the chosen index in R8 is 12 or more, the range field keeps its pre-write value and `msiFreqHz` is unchanged.
- R10: Flags stay set until cleared by a 1 on the matching `flagClr` bit. A set in the same cycle wins over a clear. `irqOut` is 1 exactly when some flag and its `srcIrqEn` bit are both 1.
- R11: A write that leaves the multi-speed oscillator disabled clears its ready bit and sets `msiFreqHz` to 0. In that case the written range field is stored without a range check.
- R12: In a cycle with `wrEn` = 0, `ctrlReg` and `msiFreqHz` do not change, even if `sysSw` or `pllSrc` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | DATA_W | Write data |
| sysSw | input | 2 | System clock switch status: 00 multi-speed, 01 16 MHz, 10 external, 11 PLL |
| pllSrc | input | 2 | PLL input: 00 none, 01 multi-speed, 10 16 MHz, 11 external |
| stbyRange | input | RANGE_W | Standby range index, used when range select is 0 |
| srcIrqEn | input | 4 | Per-source ready interrupt enables |
| flagClr | input | 4 | Write-1-to-clear for the ready flags |
| ctrlReg | output | DATA_W | Register readback |
| rdyFlags | output | 4 | Ready interrupt flags |
| irqOut | output | 1 | Interrupt request |
| msiFreqHz | output | FREQ_W | Multi-speed oscillator frequency in Hz |

## Verification
Some rules are checked on every cycle. These are the protection and forcing outcomes after writes, the freezing of register and frequency in idle cycles, the sticky flag behaviour, and the rule that a nonzero frequency implies the multi-speed ready bit. Other behaviours need chosen write sequences to be seen. These include the frequency value for each range index, the rejection that restores the old range field, the read-set range select, the ready bits keeping their value under a held source, and the one-time multi-speed flag. The bench covers them with directed writes and with a sweep over every switch status, PLL source and enable pattern.

// File: rtl/clk_ctrl_pkg.sv
`timescale 1ns/1ps
package clk_ctrl_pkg;
  localparam int SRC_N = 4;
  localparam int SRC_MSI = 0;
  localparam int SRC_HSI = 1;
  localparam int SRC_HSE = 2;
  localparam int SRC_PLL = 3;

  // register bit positions
  localparam int MSI_ON    = 0;
  localparam int MSI_RDY   = 1;
  localparam int RANGE_SEL = 2;
  localparam int RANGE_LO  = 4;
  localparam int HSI_ON    = 8;
  localparam int HSI_RDY   = 9;
  localparam int HSE_ON    = 16;
  localparam int HSE_RDY   = 17;
  localparam int PLL_ON    = 24;
  localparam int PLL_RDY   = 25;

  localparam int unsigned MSI_RANGES = 12;

  typedef enum logic [1:0] {SW_MSI = 2'b00, SW_HSI = 2'b01, SW_HSE = 2'b10, SW_PLL = 2'b11} sysSw_e;
  typedef enum logic [1:0] {PS_NONE = 2'b00, PS_MSI = 2'b01, PS_HSI = 2'b10, PS_HSE = 2'b11} pllSrc_e;

  typedef struct packed {
    logic wr;
    logic msiForce;
    logic hsiForce;
    logic hseHold;
    logic pllHold;
  } ctrlStrobe_t;

  function automatic logic [31:0] msiRangeHz(input int unsigned idx);
    if (idx < 4)       return 32'd100000 << idx;
    else if (idx < 9)  return 32'd1000000 << (idx - 4);
    else if (idx == 9) return 32'd24000000;
    else if (idx == 10) return 32'd32000000;
    else if (idx == 11) return 32'd48000000;
    else               return 32'd0;
  endfunction
endpackage

// File: rtl/clk_ctrl_msi_lut.sv
`timescale 1ns/1ps
module clk_ctrl_msi_lut
  import clk_ctrl_pkg::*;
#(
  parameter int RANGE_W = 4,
  parameter int FREQ_W  = 32
) (
  input  logic [RANGE_W-1:0] idx,
  output logic               valid,
  output logic [FREQ_W-1:0]  freqHz
);
  logic [31:0] idxWide;
  logic [31:0] rawHz;

  always_comb begin
    idxWide = 32'(idx);
    valid   = idxWide < MSI_RANGES;
    rawHz   = msiRangeHz(idxWide);
    freqHz  = FREQ_W'(rawHz);
  end
endmodule

// File: rtl/clk_ctrl_ctl.sv
`timescale 1ns/1ps
module clk_ctrl_ctl
  import clk_ctrl_pkg::*;
(
  input  logic        wrEn,
  input  logic [1:0]  sysSw,
  input  logic [1:0]  pllSrc,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe.wr       = wrEn;
    strobe.msiForce = (sysSw == SW_MSI) || (pllSrc == PS_MSI);
    strobe.hsiForce = (sysSw == SW_HSI) || (pllSrc == PS_HSI);
    strobe.hseHold  = (sysSw == SW_HSE) || (pllSrc == PS_HSE);
    strobe.pllHold  = (sysSw == SW_PLL);
  end
endmodule

// File: rtl/clk_ctrl_dp.sv
`timescale 1ns/1ps
module clk_ctrl_dp
  import clk_ctrl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FREQ_W      = 32,
  parameter int RANGE_W     = 4,
  parameter int RESET_RANGE = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [RANGE_W-1:0] stbyRange,
  input  logic [SRC_N-1:0]   srcIrqEn,
  input  logic [SRC_N-1:0]   flagClr,
  output logic [DATA_W-1:0]  ctrlQ,
  output logic [SRC_N-1:0]   flagQ,
  output logic               irq,
  output logic [FREQ_W-1:0]  freqQ
);
  // range field must sit below the 16 MHz enable bit
  localparam logic [DATA_W-1:0] RST_CTRL =
      (DATA_W'(1) << MSI_ON) | (DATA_W'(1) << MSI_RDY) |
      (DATA_W'(RESET_RANGE) << RANGE_LO);
  localparam logic [FREQ_W-1:0] RST_FREQ = FREQ_W'(msiRangeHz(RESET_RANGE));

  logic [DATA_W-1:0]  ctrlD;
  logic [FREQ_W-1:0]  freqD;
  logic [SRC_N-1:0]   setVec;
  logic [SRC_N-1:0]   flagD;
  logic               rangeSelN;
  logic [RANGE_W-1:0] wrRange;
  logic [RANGE_W-1:0] oldRange;
  logic [RANGE_W-1:0] lutIdx;
  logic               lutValid;
  logic [FREQ_W-1:0]  lutFreq;

  assign rangeSelN = ctrlQ[RANGE_SEL] | wrData[RANGE_SEL];
  assign wrRange   = wrData[RANGE_LO +: RANGE_W];
  assign oldRange  = ctrlQ[RANGE_LO +: RANGE_W];
  assign lutIdx    = rangeSelN ? wrRange : stbyRange;

  clk_ctrl_msi_lut #(.RANGE_W(RANGE_W), .FREQ_W(FREQ_W)) u_lut (
    .idx    (lutIdx),
    .valid  (lutValid),
    .freqHz (lutFreq)
  );

  always_comb begin
    ctrlD  = ctrlQ;
    freqD  = freqQ;
    setVec = '0;
    if (strobe.wr) begin
      ctrlD = '0;
      ctrlD[RANGE_SEL] = rangeSelN;
      ctrlD[RANGE_LO +: RANGE_W] = wrRange;

      // multi-speed oscillator
      if (strobe.msiForce || wrData[MSI_ON]) begin
        ctrlD[MSI_ON]  = 1'b1;
        ctrlD[MSI_RDY] = 1'b1;
        setVec[SRC_MSI] = strobe.msiForce ? !ctrlQ[MSI_ON] : 1'b1;
        if (lutValid) freqD = lutFreq;
        else          ctrlD[RANGE_LO +: RANGE_W] = oldRange;
      end else begin
        freqD = '0;
      end

      // 16 MHz internal oscillator
      if (strobe.hsiForce) begin
        ctrlD[HSI_ON]  = 1'b1;
        ctrlD[HSI_RDY] = 1'b1;
        setVec[SRC_HSI] = 1'b1;
      end else begin
        ctrlD[HSI_ON]  = wrData[HSI_ON];
        ctrlD[HSI_RDY] = wrData[HSI_ON];
        setVec[SRC_HSI] = wrData[HSI_ON];
      end

      // external oscillator
      if (strobe.hseHold) begin
        ctrlD[HSE_ON]  = 1'b1;
        ctrlD[HSE_RDY] = ctrlQ[HSE_RDY];
      end else begin
        ctrlD[HSE_ON]  = wrData[HSE_ON];
        ctrlD[HSE_RDY] = wrData[HSE_ON];
        setVec[SRC_HSE] = wrData[HSE_ON];
      end

      // main PLL
      if (strobe.pllHold) begin
        ctrlD[PLL_ON]  = 1'b1;
        ctrlD[PLL_RDY] = ctrlQ[PLL_RDY];
      end else begin
        ctrlD[PLL_ON]  = wrData[PLL_ON];
        ctrlD[PLL_RDY] = wrData[PLL_ON];
        setVec[SRC_PLL] = wrData[PLL_ON];
      end

      setVec = setVec & srcIrqEn;
    end
    flagD = (flagQ & ~flagClr) | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= RST_CTRL;
      freqQ <= RST_FREQ;
      flagQ <= '0;
    end else begin
      ctrlQ <= ctrlD;
      freqQ <= freqD;
      flagQ <= flagD;
    end
  end

  assign irq = |(flagQ & srcIrqEn);
endmodule

// File: rtl/clk_ctrl_reg.sv
`timescale 1ns/1ps
module clk_ctrl_reg
  import clk_ctrl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FREQ_W      = 32,
  parameter int RANGE_W     = 4,
  parameter int RESET_RANGE = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [1:0]         sysSw,
  input  logic [1:0]         pllSrc,
  input  logic [RANGE_W-1:0] stbyRange,
  input  logic [3:0]         srcIrqEn,
  input  logic [3:0]         flagClr,
  output logic [DATA_W-1:0]  ctrlReg,
  output logic [3:0]         rdyFlags,
  output logic               irqOut,
  output logic [FREQ_W-1:0]  msiFreqHz
);
  ctrlStrobe_t strobe;

  clk_ctrl_ctl u_ctl (
    .wrEn   (wrEn),
    .sysSw  (sysSw),
    .pllSrc (pllSrc),
    .strobe (strobe)
  );

  clk_ctrl_dp #(
    .DATA_W(DATA_W), .FREQ_W(FREQ_W), .RANGE_W(RANGE_W), .RESET_RANGE(RESET_RANGE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .stbyRange (stbyRange),
    .srcIrqEn  (srcIrqEn),
    .flagClr   (flagClr),
    .ctrlQ     (ctrlReg),
    .flagQ     (rdyFlags),
    .irq       (irqOut),
    .freqQ     (msiFreqHz)
  );
endmodule

// File: rtl/clk_ctrl_chk.sv
`timescale 1ns/1ps
module clk_ctrl_chk #(
  parameter int DATA_W  = 32,
  parameter int FREQ_W  = 32,
  parameter int RANGE_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [DATA_W-1:0]  wrData,
  input logic [1:0]         sysSw,
  input logic [1:0]         pllSrc,
  input logic [RANGE_W-1:0] stbyRange,
  input logic [3:0]         srcIrqEn,
  input logic [3:0]         flagClr,
  input logic [DATA_W-1:0]  ctrlReg,
  input logic [3:0]         rdyFlags,
  input logic               irqOut,
  input logic [FREQ_W-1:0]  msiFreqHz
);
  a_r3_pll_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sysSw == 2'b11) |=> (ctrlReg[24] && ctrlReg[25] == $past(ctrlReg[25])));

  a_r4_hse_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (sysSw == 2'b10 || pllSrc == 2'b11)) |=>
      (ctrlReg[16] && ctrlReg[17] == $past(ctrlReg[17])));

  a_r5_hsi_force: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (sysSw == 2'b01 || pllSrc == 2'b10)) |=> (ctrlReg[8] && ctrlReg[9]));

  a_r6_msi_force: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (sysSw == 2'b00 || pllSrc == 2'b01)) |=> (ctrlReg[0] && ctrlReg[1]));

  a_r6_no_reflag: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (sysSw == 2'b00 || pllSrc == 2'b01) && ctrlReg[0]) |=>
      (rdyFlags[0] == ($past(rdyFlags[0]) & ~$past(flagClr[0]))));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (rdyFlags == ($past(rdyFlags) & ~$past(flagClr))));

  a_r11_freq_rdy: assert property (@(posedge clk) disable iff (!rstN)
    (msiFreqHz != '0) |-> ctrlReg[1]);

  a_r12_idle: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(ctrlReg) && $stable(msiFreqHz)));
endmodule

bind clk_ctrl_reg clk_ctrl_chk #(.DATA_W(DATA_W), .FREQ_W(FREQ_W), .RANGE_W(RANGE_W)) u_chk (.*);

// File: tb/clk_ctrl_reg_bench.sv
`timescale 1ns/1ps
module clk_ctrl_reg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0]  sysSw = 2'b01;
  logic [1:0]  pllSrc = 2'b00;
  logic [3:0]  stbyRange = '0;
  logic [3:0]  srcIrqEn = '0;
  logic [3:0]  flagClr = '0;
  logic [31:0] ctrlReg;
  logic [3:0]  rdyFlags;
  logic        irqOut;
  logic [31:0] msiFreqHz;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] eCtrl;
  logic [3:0]  eFlags;
  logic [31:0] eFreq;

  always #2.5 clk = ~clk;

  clk_ctrl_reg u_clk_ctrl_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .sysSw(sysSw),
    .pllSrc(pllSrc), .stbyRange(stbyRange), .srcIrqEn(srcIrqEn), .flagClr(flagClr),
    .ctrlReg(ctrlReg), .rdyFlags(rdyFlags), .irqOut(irqOut), .msiFreqHz(msiFreqHz)
  );

  function automatic logic [31:0] freqOf(int idx);
    if (idx < 4) return 32'(100000 * (1 << idx));
    if (idx < 9) return 32'(1000000 * (1 << (idx - 4)));
    if (idx == 9) return 32'd24000000;
    if (idx == 10) return 32'd32000000;
    return 32'd48000000;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check(tag, "ctrlReg", 64'(ctrlReg), 64'(eCtrl));
    check(tag, "rdyFlags", 64'(rdyFlags), 64'(eFlags));
    check(tag, "msiFreqHz", 64'(msiFreqHz), 64'(eFreq));
    check(tag, "irqOut", 64'(irqOut), 64'(|(eFlags & srcIrqEn)));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; flagClr = '0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    eCtrl = 32'h63; eFlags = '0; eFreq = 32'd4000000;
  endtask

  // expected register update computed from the requirement text
  task automatic modelWrite(logic [31:0] d, logic [1:0] sw, logic [1:0] src,
                            logic [3:0] stby, logic [3:0] ien, logic [3:0] clr);
    logic [31:0] n;
    logic [3:0] s;
    logic rs, fMsi;
    int idx;
    n = '0; s = '0;
    rs = eCtrl[2] | d[2];
    n[2] = rs;
    n[7:4] = d[7:4];
    idx = rs ? int'(d[7:4]) : int'(stby);
    fMsi = (sw == 2'b00) || (src == 2'b01);
    if (fMsi || d[0]) begin
      n[0] = 1'b1; n[1] = 1'b1;
      s[0] = fMsi ? !eCtrl[0] : 1'b1;
      if (idx < 12) eFreq = freqOf(idx);
      else n[7:4] = eCtrl[7:4];
    end else eFreq = '0;
    if (sw == 2'b01 || src == 2'b10) begin n[8] = 1; n[9] = 1; s[1] = 1; end
    else begin n[8] = d[8]; n[9] = d[8]; s[1] = d[8]; end
    if (sw == 2'b10 || src == 2'b11) begin n[16] = 1; n[17] = eCtrl[17]; end
    else begin n[16] = d[16]; n[17] = d[16]; s[2] = d[16]; end
    if (sw == 2'b11) begin n[24] = 1; n[25] = eCtrl[25]; end
    else begin n[24] = d[24]; n[25] = d[24]; s[3] = d[24]; end
    eCtrl = n;
    eFlags = (eFlags & ~clr) | (s & ien);
  endtask

  task automatic doWrite(string tag, logic [31:0] d, logic [1:0] sw, logic [1:0] src,
                         logic [3:0] stby, logic [3:0] ien, logic [3:0] clr);
    @(negedge clk);
    wrData = d; sysSw = sw; pllSrc = src; stbyRange = stby; srcIrqEn = ien;
    flagClr = clr; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; flagClr = '0;
    modelWrite(d, sw, src, stby, ien, clr);
    checkAll(tag);
  endtask

  task automatic doIdle(string tag, logic [3:0] clr, logic [1:0] sw, logic [1:0] src);
    @(negedge clk);
    flagClr = clr; sysSw = sw; pllSrc = src; wrData = 32'hFFFF_FFFF;
    @(negedge clk);
    flagClr = '0;
    eFlags = eFlags & ~clr;
    checkAll(tag);
  endtask

  function automatic logic [31:0] mk(bit pll, bit hse, bit hsi, bit msi, bit rsel, logic [3:0] rng);
    logic [31:0] d;
    d = '0;
    d[24] = pll; d[16] = hse; d[8] = hsi; d[0] = msi; d[2] = rsel; d[7:4] = rng;
    return d;
  endfunction

  initial begin
    #900us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    checkAll("R1");

    // standby range path, then rejection of an out-of-range index
    doWrite("R8", mk(0,0,0,1,0,4'd0), 2'b01, 2'b00, 4'd9, 4'b0000, 4'b0000);
    doWrite("R9", mk(0,0,0,1,0,4'd5), 2'b01, 2'b00, 4'd13, 4'b0000, 4'b0000);
    // ready bits written high are ignored; range select sets and sticks
    doWrite("R2", mk(0,0,0,1,1,4'd11) | 32'h0202_0202, 2'b01, 2'b00, 4'd0, 4'b0000, 4'b0000);
    doWrite("R2", mk(0,0,0,1,0,4'd3), 2'b01, 2'b00, 4'd14, 4'b0000, 4'b0000);
    doWrite("R9", mk(0,0,0,1,0,4'd15), 2'b01, 2'b00, 4'd0, 4'b0000, 4'b0000);
    // multi-speed forced while already on: no flag
    doWrite("R6", mk(0,0,0,0,0,4'd7), 2'b00, 2'b00, 4'd0, 4'b0001, 4'b0000);
    // multi-speed switched off
    doWrite("R11", mk(0,0,0,0,0,4'd14), 2'b01, 2'b00, 4'd0, 4'b0001, 4'b0000);
    // forced on via PLL source from off: flag raised
    doWrite("R6", mk(0,0,0,0,0,4'd8), 2'b11, 2'b01, 4'd0, 4'b0001, 4'b0000);
    doIdle("R10", 4'b0001, 2'b10, 2'b11);
    // set wins over clear in the same cycle
    doWrite("R10", mk(0,0,1,1,0,4'd2), 2'b01, 2'b00, 4'd0, 4'b0011, 4'b0011);
    doIdle("R10", 4'b1111, 2'b01, 2'b00);
    // unprotected external and PLL turned on
    doWrite("R7", mk(1,1,1,1,0,4'd2), 2'b01, 2'b00, 4'd0, 4'b1100, 4'b0000);
    doIdle("R10", 4'b1111, 2'b01, 2'b00);
    // PLL clear attempt while PLL is the system clock
    doWrite("R3", mk(0,1,1,1,0,4'd2), 2'b11, 2'b00, 4'd0, 4'b1111, 4'b0000);
    doIdle("R12", 4'b1111, 2'b11, 2'b10);
    // external clear attempt while it is the system clock, then via PLL source
    doWrite("R4", mk(1,0,1,1,0,4'd2), 2'b10, 2'b00, 4'd0, 4'b1111, 4'b0000);
    doWrite("R7", mk(0,0,1,1,0,4'd2), 2'b01, 2'b00, 4'd0, 4'b0000, 4'b0000);
    doWrite("R4", mk(0,1,1,1,0,4'd2), 2'b01, 2'b11, 4'd0, 4'b0100, 4'b0000);
    // 16 MHz clear attempt while it feeds the PLL
    doWrite("R5", mk(0,0,0,1,0,4'd2), 2'b00, 2'b10, 4'd0, 4'b0010, 4'b0000);
    doIdle("R12", 4'b0000, 2'b00, 2'b00);

    // sweep with fresh range select
    doReset();
    checkAll("R1");
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        for (int e = 0; e < 16; e++) begin
          logic [31:0] d;
          d = mk(e[3], e[2], e[1], e[0], (s == 3 && p == 3 && e > 7), 4'((e * 5 + s * 3 + p) % 16));
          doWrite("R7", d, 2'(s), 2'(p), 4'((e + s + p) % 16), 4'(e) ^ {2'(p), 2'(s)}, 4'b0000);
          doIdle("R10", {2'(s), 2'(p)}, 2'(3 - s), 2'(p));
        end
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule